// File: doc/BRIEF.md
# Instruction Restart Trace Registers

This block sits beside a processor bus and keeps a one-instruction history for fault recovery. It records the segmented program counter each time an instruction fetch cycle completes. It also counts the bus cycles that complete after that fetch. When a memory fault is signalled, both values are locked. A recovery handler can then read them and work out how far the interrupted instruction got, undo its side effects and restart it.

The handler reads the held values through a four-word register window. Once recovery is done, it writes to the control word to release the lock. Address translation and the recovery software itself are outside the block.

Top module: `restart_trace`

## Requirements
- R1: While `rst` is high at a clock edge, the segment, offset, count and frozen flag all become zero.
- R2: When not frozen, a cycle with `bus_done` and `bus_ifetch` both high stores `bus_seg` and `bus_off` as two separate fields, visible on `trace_seg` and `trace_off` after that edge.
- R3: When not frozen, that same fetch completion sets the count to zero.
- R4: When not frozen, each cycle with `bus_done` high and `bus_ifetch` low adds one to the count. A cycle with `bus_done` low leaves the count unchanged.
- R5: The 8-bit count stops at 255 and never wraps to zero.
- R6: `fault_in` high at an edge sets `trace_frozen` after that edge. Any bus completion in that same cycle is still applied. While frozen, later fetches and completions change neither the PC nor the count.
- R7: A fault in the same cycle as a fetch completion freezes the PC of that fetch together with a count of zero.
- R8: A further fault while already frozen leaves the PC, the count and the flag unchanged.
- R9: A write (`reg_wr` high) to offset 3 with data bit 0 set clears the frozen flag, and capture resumes from the next cycle. A fault in the same cycle keeps the flag set. A write to any other offset, or with bit 0 clear, has no effect. After a release, the count continues from the value it held.
- R10: `reg_rdata` is combinational on `reg_addr`. Offset 0 gives the segment in bits 6:0. Offset 1 gives the offset. Offset 2 gives the count in bits 7:0. Offset 3 gives the frozen flag in bit 0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_done | input | 1 | A bus cycle completes in this clock |
| bus_ifetch | input | 1 | The completing cycle is an instruction fetch |
| bus_seg | input | 7 | Segment number of the current address |
| bus_off | input | 16 | Offset of the current address |
| fault_in | input | 1 | Memory fault indication |
| reg_addr | input | 2 | Register window offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| trace_seg | output | 7 | Held fetch segment |
| trace_off | output | 16 | Held fetch offset |
| trace_cnt | output | 8 | Bus cycles since that fetch |
| trace_frozen | output | 1 | History is locked by a fault |

## Verification
Two pairs of events can land on the same clock, and both are tested.

The first pair is a fault and a capture event. The bench raises `fault_in` together with a completing fetch, and separately together with a completing data cycle. In the fetch case, the locked PC must be the new fetch address with a count of zero. In the data-cycle case, the count must include that final cycle.

The second pair is a fault and the release write. The bench raises both in one cycle and requires the flag to stay set.

A reference model in the bench predicts every cycle. A scoreboard compares its prediction with the outputs after each edge.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam int SEG_W  = 7;
    localparam int OFF_W  = 16;
    localparam int CNT_W  = 8;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;

    localparam int RESUME_BIT = 0;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
    } seg_pc_t;

    typedef enum logic [ADDR_W-1:0] {
        WIN_SEG  = 2'd0,
        WIN_OFF  = 2'd1,
        WIN_CNT  = 2'd2,
        WIN_CTRL = 2'd3
    } win_addr_e;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_FETCH = 2'd1,
        EV_DATA  = 2'd2
    } bus_ev_e;

    function automatic bus_ev_e classify(input logic done, input logic ifetch);
        if (!done)      return EV_NONE;
        else if (ifetch) return EV_FETCH;
        else            return EV_DATA;
    endfunction

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (&v) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/irt_freeze_ctl.sv
module irt_freeze_ctl (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic resume_req,
    output logic frozen
);
    logic frozen_q;

    always_ff @(posedge clk) begin
        if (rst)             frozen_q <= 1'b0;
        else if (fault)      frozen_q <= 1'b1;
        else if (resume_req) frozen_q <= 1'b0;
    end

    assign frozen = frozen_q;

    assert_fault_locks_R6: assert property (@(posedge clk) disable iff (rst)
        fault |=> frozen_q);

    assert_refault_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && !resume_req) |=> frozen_q);

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        (resume_req && !fault) |=> !frozen_q);

endmodule

// File: rtl/irt_pc_latch.sv
module irt_pc_latch
    import irt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cap_en,
    input  bus_ev_e ev,
    input  seg_pc_t pc_in,
    output seg_pc_t pc_q
);
    seg_pc_t pc_r;

    always_ff @(posedge clk) begin
        if (rst)                         pc_r <= '0;
        else if (cap_en && ev == EV_FETCH) pc_r <= pc_in;
    end

    assign pc_q = pc_r;

    assert_fetch_loads_R2: assert property (@(posedge clk) disable iff (rst)
        (cap_en && ev == EV_FETCH) |=> (pc_r == $past(pc_in)));

    assert_locked_pc_R6: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(pc_r));

endmodule

// File: rtl/irt_cycle_cnt.sv
module irt_cycle_cnt
    import irt_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_en,
    input  bus_ev_e      ev,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cap_en) begin
            case (ev)
                EV_FETCH: cnt_q <= '0;
                EV_DATA:  cnt_q <= (cnt_q == TOP) ? cnt_q : cnt_q + 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt = cnt_q;

    assert_fetch_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cap_en && ev == EV_FETCH) |=> (cnt_q == '0));

    assert_data_step_R4: assert property (@(posedge clk) disable iff (rst)
        (cap_en && ev == EV_DATA && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == TOP && ev != EV_FETCH) |=> (cnt_q == TOP));

    assert_locked_cnt_R6: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(cnt_q));

endmodule

// File: rtl/irt_reg_win.sv
module irt_reg_win
    import irt_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              wbit,
    input  seg_pc_t           pc,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              frozen,
    output logic [DATA_W-1:0] rdata,
    output logic              resume_req
);
    assign resume_req = wr && wbit && (addr == WIN_CTRL);

    always_comb begin
        rdata = '0;
        case (win_addr_e'(addr))
            WIN_SEG:  rdata[SEG_W-1:0] = pc.seg;
            WIN_OFF:  rdata[OFF_W-1:0] = pc.off;
            WIN_CNT:  rdata[CNT_W-1:0] = cnt;
            WIN_CTRL: rdata[0]         = frozen;
            default:  rdata            = '0;
        endcase
    end

endmodule

// File: rtl/restart_trace.sv
module restart_trace
    import irt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_done,
    input  logic              bus_ifetch,
    input  logic [SEG_W-1:0]  bus_seg,
    input  logic [OFF_W-1:0]  bus_off,
    input  logic              fault_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [SEG_W-1:0]  trace_seg,
    output logic [OFF_W-1:0]  trace_off,
    output logic [CNT_W-1:0]  trace_cnt,
    output logic              trace_frozen
);
    bus_ev_e ev;
    seg_pc_t pc_in, pc_q;
    logic    frozen, resume_req, cap_en;
    logic [CNT_W-1:0] cnt;
    logic    unused_wdata;

    assign unused_wdata = ^reg_wdata;
    assign ev     = classify(bus_done, bus_ifetch);
    assign pc_in  = '{seg: bus_seg, off: bus_off};
    assign cap_en = !frozen;

    irt_freeze_ctl u_frz (
        .clk(clk), .rst(rst), .fault(fault_in),
        .resume_req(resume_req), .frozen(frozen)
    );

    irt_pc_latch u_pc (
        .clk(clk), .rst(rst), .cap_en(cap_en), .ev(ev),
        .pc_in(pc_in), .pc_q(pc_q)
    );

    irt_cycle_cnt #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .cap_en(cap_en), .ev(ev), .cnt(cnt)
    );

    irt_reg_win u_win (
        .addr(reg_addr), .wr(reg_wr), .wbit(reg_wdata[RESUME_BIT]),
        .pc(pc_q), .cnt(cnt), .frozen(frozen),
        .rdata(reg_rdata), .resume_req(resume_req)
    );

    assign trace_seg    = pc_q.seg;
    assign trace_off    = pc_q.off;
    assign trace_cnt    = cnt;
    assign trace_frozen = frozen;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (trace_cnt == '0 && !trace_frozen && trace_seg == '0 && trace_off == '0));

    assert_fetch_fault_R7: assert property (@(posedge clk) disable iff (rst)
        (fault_in && !frozen && bus_done && bus_ifetch)
        |=> (trace_frozen && trace_cnt == '0 && trace_off == $past(bus_off)));

endmodule

// File: tb/restart_trace_test.sv
module restart_trace_test;
    import irt_pkg::*;

    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_done = 0, bus_ifetch = 0, fault_in = 0, reg_wr = 0;
    logic [6:0]  bus_seg = '0;
    logic [15:0] bus_off = '0, reg_wdata = '0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_rdata;
    logic [6:0]  trace_seg;
    logic [15:0] trace_off;
    logic [7:0]  trace_cnt;
    logic        trace_frozen;

    int errors = 0;
    int checks = 0;

    typedef struct {
        string      tag;
        logic [6:0] seg;
        logic [15:0] off;
        logic [7:0] cnt;
        logic       frz;
    } exp_t;

    exp_t sb[$];

    logic [6:0]  m_seg = '0;
    logic [15:0] m_off = '0;
    logic [7:0]  m_cnt = '0;
    logic        m_frz = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    restart_trace uut (
        .clk(clk), .rst(rst), .bus_done(bus_done), .bus_ifetch(bus_ifetch),
        .bus_seg(bus_seg), .bus_off(bus_off), .fault_in(fault_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .trace_seg(trace_seg), .trace_off(trace_off),
        .trace_cnt(trace_cnt), .trace_frozen(trace_frozen)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus at a falling edge, update the model, push the prediction.
    task automatic step(input string tag, input bit fetch, input bit done, input bit flt,
                        input bit wr, input logic [1:0] a, input logic [15:0] wd,
                        input logic [6:0] s, input logic [15:0] o);
        bit clr;
        exp_t e;
        bus_done = done; bus_ifetch = fetch; fault_in = flt;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; bus_seg = s; bus_off = o;
        @(posedge clk);
        clr = wr && (a == 2'd3) && wd[0];
        if (!m_frz) begin
            if (done && fetch) begin m_seg = s; m_off = o; m_cnt = 8'd0; end
            else if (done && m_cnt != 8'hFF) m_cnt = m_cnt + 8'd1;
        end
        if (flt) m_frz = 1'b1;
        else if (clr) m_frz = 1'b0;
        e.tag = tag; e.seg = m_seg; e.off = m_off; e.cnt = m_cnt; e.frz = m_frz;
        sb.push_back(e);
        @(negedge clk);
        bus_done = 0; bus_ifetch = 0; fault_in = 0; reg_wr = 0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [15:0] exp);
        reg_addr = a;
        #1;
        chk(tag, {16'd0, reg_rdata}, {16'd0, exp});
        @(negedge clk);
    endtask

    // Monitor: compare outputs after each edge against the queued prediction.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " seg"}, {25'd0, trace_seg}, {25'd0, e.seg});
                chk({e.tag, " off"}, {16'd0, trace_off}, {16'd0, e.off});
                chk({e.tag, " cnt"}, {24'd0, trace_cnt}, {24'd0, e.cnt});
                chk({e.tag, " frz"}, {31'd0, trace_frozen}, {31'd0, e.frz});
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 seg", {25'd0, trace_seg}, 32'd0);
        chk("R1 cnt", {24'd0, trace_cnt}, 32'd0);
        chk("R1 frz", {31'd0, trace_frozen}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        step("R2 R3 fetch", 1, 1, 0, 0, 0, 0, 7'h55, 16'hBEEF);
        step("R4 data1", 0, 1, 0, 0, 0, 0, 7'h01, 16'h1111);
        step("R4 idle",  0, 0, 0, 0, 0, 0, 7'h02, 16'h2222);
        step("R4 data2", 0, 1, 0, 0, 0, 0, 7'h03, 16'h3333);
        step("R4 fetch ignored without done", 1, 0, 0, 0, 0, 0, 7'h04, 16'h4444);
        step("R4 data3", 0, 1, 0, 0, 0, 0, 7'h05, 16'h5555);
        for (int i = 0; i < 260; i++)
            step("R5 saturate", 0, 1, 0, 0, 0, 0, 7'h06, 16'h6666);
        step("R3 fetch clears", 1, 1, 0, 0, 0, 0, 7'h2A, 16'h1234);
        step("R4 data", 0, 1, 0, 0, 0, 0, 7'h00, 16'h0);
        step("R4 data", 0, 1, 0, 0, 0, 0, 7'h00, 16'h0);
        step("R6 fault with data", 0, 1, 1, 0, 0, 0, 7'h00, 16'h0);
        step("R6 fetch while frozen", 1, 1, 0, 0, 0, 0, 7'h7F, 16'hFFFF);
        step("R6 data while frozen", 0, 1, 0, 0, 0, 0, 7'h00, 16'h0);
        step("R8 second fault", 1, 1, 1, 0, 0, 0, 7'h11, 16'h2222);
        rd("R10 read seg", 2'd0, 16'h002A);
        rd("R10 read off", 2'd1, 16'h1234);
        rd("R10 read cnt", 2'd2, 16'h0003);
        rd("R10 read flag", 2'd3, 16'h0001);
        step("R9 wrong offset", 0, 0, 0, 1, 2'd2, 16'hFFFF, 7'h0, 16'h0);
        step("R9 bit0 clear", 0, 0, 0, 1, 2'd3, 16'hFFFE, 7'h0, 16'h0);
        step("R9 clear with fault", 0, 0, 1, 1, 2'd3, 16'h0001, 7'h0, 16'h0);
        step("R9 release", 0, 1, 0, 1, 2'd3, 16'h0001, 7'h0, 16'h0);
        step("R9 count continues", 0, 1, 0, 0, 0, 0, 7'h0, 16'h0);
        rd("R10 flag after release", 2'd3, 16'h0000);
        step("R7 fault on fetch", 1, 1, 1, 0, 0, 0, 7'h33, 16'hCAFE);
        rd("R7 read seg", 2'd0, 16'h0033);
        rd("R7 read cnt", 2'd2, 16'h0000);
        step("R1 reset again", 1, 1, 0, 0, 0, 0, 7'h0, 16'h0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears frz", {31'd0, trace_frozen}, 32'd0);
        chk("R1 reset clears off", {16'd0, trace_off}, 32'd0);
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule